// File: doc/BRIEF.md
# Address Region Security Filter

This block sits in front of a memory or peripheral target and screens each bus transaction before it goes through. Every request carries an address, a read or write flag and a secure or non-secure flag. The block compares the address with up to eight programmable windows. Each window has an inclusive lower and upper bound, an enable bit, a flag that marks it as secure space, and four permission bits. The permission bits cover secure read, secure write, non-secure read and non-secure write.

One cycle after a request is accepted, the block returns a pass or an error response. If several enabled windows contain the address, the highest-numbered one decides. An address that falls in no enabled window is refused. A non-secure requester can never reach a window marked as secure space. A secure requester is judged only by the window's secure permission bits.

Software programs the windows through a simple register write port. The first refused transaction is recorded in a sticky fault record, which holds the address and the request flags. That record drives an interrupt line until software clears it through the same write port.

Top module: `addr_region_guard`

## Requirements
- R1: After reset, resp_valid and fault_irq are 0, req_ready is 1 and every window is disabled with zero bounds and zero attributes, so any request is refused.
- R2: A window matches when its enable bit (attribute bit 0) is 1 and base <= address <= top, with both bounds included. A disabled window never matches.
- R3: When several windows match, the one with the highest index decides the outcome.
- R4: A request whose address matches no enabled window gets an error response.
- R5: A secure request (req_secure=1) passes only if the winning window's secure-read bit (attribute bit 1) is set for a read, or its secure-write bit (attribute bit 2) is set for a write. The secure-space flag does not affect it.
- R6: A non-secure request passes only if the winning window's secure-space flag (attribute bit 5) is 0 and its non-secure-read bit (attribute bit 3) is set for a read, or its non-secure-write bit (attribute bit 4) is set for a write.
- R7: A request accepted at a clock edge (req_valid and req_ready both 1) has its response on resp_valid from that edge on. Exactly one of resp_ok and resp_err is 1 while resp_valid is 1.
- R8: While resp_valid=1 and resp_ready=0, req_ready is 0 and the response holds its value. When resp_ready=1, or when no response is pending, req_ready is 1.
- R9: A refused request that arrives while fault_irq=0 records its address, write flag and secure flag and raises fault_irq. Later refusals do not overwrite the record while it is held.
- R10: A config write with select 3 clears the fault record. If a refused request is accepted at the same edge, that request is recorded instead and fault_irq stays 1.
- R11: A config write takes effect for requests accepted after its edge. A request accepted at the same edge as the write is judged against the old window settings. Select values: 0 writes the base, 1 writes the top, 2 writes attribute bits [5:0] of cfg_wdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | IDX_W | Window index of the write |
| cfg_sel | input | 2 | 0 base, 1 top, 2 attributes, 3 clear fault record |
| cfg_wdata | input | ADDR_W | Write data |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | ADDR_W | Request address |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_secure | input | 1 | 1 for a secure request |
| resp_valid | output | 1 | Response present |
| resp_ready | input | 1 | Response consumer ready |
| resp_ok | output | 1 | Request passed |
| resp_err | output | 1 | Request refused |
| fault_irq | output | 1 | Fault record held |
| fault_addr | output | ADDR_W | Recorded fault address |
| fault_write | output | 1 | Recorded write flag |
| fault_secure | output | 1 | Recorded secure flag |

## Verification
The bench checks addresses exactly at the base, at the top, and one past each end. A design with an exclusive compare would refuse the boundary addresses, and one with a loose compare would pass the outside ones. It places a restrictive window inside a permissive lower-numbered one: reversed priority would let a non-secure read through. It gives a secure-space window all four permission bits to catch a design that trusts the non-secure bits alone. It also lines up a fault clear with a new refusal, and a window rewrite with a request at the same edge. A design that orders these events wrongly would lose the fault or judge the request against the new settings. Backpressure runs keep the response stalled so that a design that drops or replaces the pending response is caught.

// File: rtl/arg_pkg.sv
package arg_pkg;

    // Window attribute word; the first member is the most significant bit.
    typedef struct packed {
        logic sec_space;  // bit 5
        logic ns_wr;      // bit 4
        logic ns_rd;      // bit 3
        logic s_wr;       // bit 2
        logic s_rd;       // bit 1
        logic en;         // bit 0
    } region_attr_t;

    localparam int ATTR_W = $bits(region_attr_t);

    typedef enum logic [1:0] {
        CFG_BASE  = 2'd0,
        CFG_TOP   = 2'd1,
        CFG_ATTR  = 2'd2,
        CFG_CLEAR = 2'd3
    } cfg_sel_e;

    function automatic logic access_allowed(region_attr_t a, logic wr, logic sec);
        if (sec) return wr ? a.s_wr : a.s_rd;
        return !a.sec_space && (wr ? a.ns_wr : a.ns_rd);
    endfunction

endpackage

// File: rtl/arg_region_file.sv
module arg_region_file
    import arg_pkg::*;
#(
    parameter int N      = 8,
    parameter int ADDR_W = 32,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cfg_we,
    input  logic [IDX_W-1:0]             cfg_idx,
    input  logic [1:0]                   cfg_sel,
    input  logic [ADDR_W-1:0]            cfg_wdata,
    output logic [N-1:0][ADDR_W-1:0]     base_q,
    output logic [N-1:0][ADDR_W-1:0]     top_q,
    output region_attr_t [N-1:0]         attr_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            top_q  <= '0;
            attr_q <= '0;
        end else if (cfg_we) begin
            for (int i = 0; i < N; i++) begin
                if (cfg_idx == IDX_W'(i)) begin
                    case (cfg_sel_e'(cfg_sel))
                        CFG_BASE: base_q[i] <= cfg_wdata;
                        CFG_TOP:  top_q[i]  <= cfg_wdata;
                        CFG_ATTR: attr_q[i] <= region_attr_t'(cfg_wdata[ATTR_W-1:0]);
                        default:  ;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/arg_match.sv
module arg_match
    import arg_pkg::*;
#(
    parameter int N      = 8,
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]            addr,
    input  logic [N-1:0][ADDR_W-1:0]     base_q,
    input  logic [N-1:0][ADDR_W-1:0]     top_q,
    input  region_attr_t [N-1:0]         attr_q,
    output logic                         hit,
    output region_attr_t                 win_attr
);

    logic [N-1:0] in_win;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            in_win[i] = attr_q[i].en && (addr >= base_q[i]) && (addr <= top_q[i]);
        end
    end

    // Walk upward so the highest-numbered window that matches decides (R3).
    always_comb begin
        hit      = 1'b0;
        win_attr = '0;
        for (int i = 0; i < N; i++) begin
            if (in_win[i]) begin
                hit      = 1'b1;
                win_attr = attr_q[i];
            end
        end
    end

endmodule

// File: rtl/arg_fault_log.sv
module arg_fault_log #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              deny,
    input  logic              clear,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              sec,
    output logic              valid,
    output logic [ADDR_W-1:0] addr_q,
    output logic              wr_q,
    output logic              sec_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid  <= 1'b0;
            addr_q <= '0;
            wr_q   <= 1'b0;
            sec_q  <= 1'b0;
        end else if (deny && (!valid || clear)) begin
            valid  <= 1'b1;
            addr_q <= addr;
            wr_q   <= wr;
            sec_q  <= sec;
        end else if (clear) begin
            valid  <= 1'b0;
        end
    end

    a_r9_record_sticky: assert property (@(posedge clk) disable iff (rst)
        (valid && !clear) |=> (valid && $stable(addr_q) && $stable(wr_q) && $stable(sec_q)));

    a_r10_clear_drops: assert property (@(posedge clk) disable iff (rst)
        (clear && !deny) |=> !valid);

    a_r9_deny_raises: assert property (@(posedge clk) disable iff (rst)
        deny |=> valid);

endmodule

// File: rtl/addr_region_guard.sv
module addr_region_guard
    import arg_pkg::*;
#(
    parameter int N      = 8,
    parameter int ADDR_W = 32,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_secure,
    output logic              resp_valid,
    input  logic              resp_ready,
    output logic              resp_ok,
    output logic              resp_err,
    output logic              fault_irq,
    output logic [ADDR_W-1:0] fault_addr,
    output logic              fault_write,
    output logic              fault_secure
);

    logic [N-1:0][ADDR_W-1:0] base_q;
    logic [N-1:0][ADDR_W-1:0] top_q;
    region_attr_t [N-1:0]     attr_q;
    region_attr_t             win_attr;
    logic                     hit;
    logic                     allow;
    logic                     accept;
    logic                     clear;

    arg_region_file #(.N(N), .ADDR_W(ADDR_W)) i_regions (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .base_q    (base_q),
        .top_q     (top_q),
        .attr_q    (attr_q)
    );

    arg_match #(.N(N), .ADDR_W(ADDR_W)) i_match (
        .addr     (req_addr),
        .base_q   (base_q),
        .top_q    (top_q),
        .attr_q   (attr_q),
        .hit      (hit),
        .win_attr (win_attr)
    );

    assign req_ready = !resp_valid || resp_ready;
    assign accept    = req_valid && req_ready;
    assign allow     = hit && access_allowed(win_attr, req_write, req_secure);
    assign clear     = cfg_we && (cfg_sel == CFG_CLEAR);

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_ok    <= 1'b0;
            resp_err   <= 1'b0;
        end else if (accept) begin
            resp_valid <= 1'b1;
            resp_ok    <= allow;
            resp_err   <= !allow;
        end else if (resp_ready) begin
            resp_valid <= 1'b0;
        end
    end

    arg_fault_log #(.ADDR_W(ADDR_W)) i_fault (
        .clk    (clk),
        .rst    (rst),
        .deny   (accept && !allow),
        .clear  (clear),
        .addr   (req_addr),
        .wr     (req_write),
        .sec    (req_secure),
        .valid  (fault_irq),
        .addr_q (fault_addr),
        .wr_q   (fault_write),
        .sec_q  (fault_secure)
    );

    a_r7_one_outcome: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> (resp_ok ^ resp_err));

    a_r8_hold_stalled: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_ok) && $stable(resp_err)));

    a_r4_miss_refused: assert property (@(posedge clk) disable iff (rst)
        (accept && !hit) |=> (resp_valid && resp_err));

    a_r7_accept_responds: assert property (@(posedge clk) disable iff (rst)
        accept |=> resp_valid);

endmodule

// File: tb/test_addr_region_guard.sv
module test_addr_region_guard;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int AW = 32;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [IW-1:0] cfg_idx = '0;
    logic [1:0]    cfg_sel = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          req_write = 1'b0;
    logic          req_secure = 1'b0;
    logic          resp_valid;
    logic          resp_ready = 1'b1;
    logic          resp_ok, resp_err;
    logic          fault_irq;
    logic [AW-1:0] fault_addr;
    logic          fault_write, fault_secure;

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_region_guard #(.N(N), .ADDR_W(AW)) i_addr_region_guard (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_secure(req_secure),
        .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_ok(resp_ok),
        .resp_err(resp_err), .fault_irq(fault_irq), .fault_addr(fault_addr),
        .fault_write(fault_write), .fault_secure(fault_secure)
    );

    // Reference model state
    logic [AW-1:0] mb [N];
    logic [AW-1:0] mt [N];
    logic [5:0]    ma [N];
    bit            m_rv, m_ok, m_fv, m_fw, m_fs;
    logic [AW-1:0] m_fa;
    int            checks = 0;
    int            fails  = 0;
    bit            done   = 0;

    function automatic bit model_allow(logic [AW-1:0] a, bit wr, bit sec);
        int win = -1;
        logic [5:0] at;
        for (int i = 0; i < N; i++)
            if (ma[i][0] && mb[i] <= a && a <= mt[i]) win = i;
        if (win < 0) return 0;
        at = ma[win];
        if (sec) return wr ? at[2] : at[1];
        return !at[5] && (wr ? at[4] : at[3]);
    endfunction

    task automatic compare(input string t);
        logic [AW+5:0] act, exp;
        bit e_ready;
        e_ready = !m_rv || resp_ready;
        act = {req_ready, resp_valid,
               resp_valid ? {resp_ok, resp_err} : 2'b00,
               fault_irq,
               fault_irq ? {fault_addr, fault_write, fault_secure} : {(AW+2){1'b0}}};
        exp = {e_ready, m_rv,
               m_rv ? {m_ok, !m_ok} : 2'b00,
               m_fv,
               m_fv ? {m_fa, m_fw, m_fs} : {(AW+2){1'b0}}};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", t, act, exp);
        end
    endtask

    task automatic step(input string t);
        bit acc, dec, clr;
        @(posedge clk);
        if (rst) begin
            m_rv = 0; m_ok = 0; m_fv = 0; m_fw = 0; m_fs = 0; m_fa = '0;
            for (int i = 0; i < N; i++) begin mb[i] = '0; mt[i] = '0; ma[i] = '0; end
        end else begin
            acc = req_valid && (!m_rv || resp_ready);
            dec = model_allow(req_addr, req_write, req_secure);
            clr = cfg_we && cfg_sel == 2'd3;
            if (acc) begin m_rv = 1; m_ok = dec; end
            else if (resp_ready) m_rv = 0;
            if (acc && !dec && (!m_fv || clr)) begin
                m_fv = 1; m_fa = req_addr; m_fw = req_write; m_fs = req_secure;
            end else if (clr) m_fv = 0;
            if (cfg_we) begin
                case (cfg_sel)
                    2'd0: mb[cfg_idx] = cfg_wdata;
                    2'd1: mt[cfg_idx] = cfg_wdata;
                    2'd2: ma[cfg_idx] = cfg_wdata[5:0];
                    default: ;
                endcase
            end
        end
        @(negedge clk);
        compare(t);
    endtask

    task automatic cfg(input int idx, input int sel, input logic [AW-1:0] d);
        cfg_we = 1; cfg_idx = IW'(idx); cfg_sel = 2'(sel); cfg_wdata = d;
        step("R11 cfg");
        cfg_we = 0;
    endtask

    task automatic region(input int idx, input logic [AW-1:0] b, input logic [AW-1:0] tp, input logic [5:0] at);
        cfg(idx, 0, b);
        cfg(idx, 1, tp);
        cfg(idx, 2, AW'(at));
    endtask

    task automatic req(input logic [AW-1:0] a, input bit wr, input bit sec, input string t);
        req_valid = 1; req_addr = a; req_write = wr; req_secure = sec;
        step(t);
        req_valid = 0;
    endtask

    initial begin
        rst = 1;
        step("R1 reset");
        step("R1 reset");
        rst = 0;
        step("R1 idle after reset");
        req(32'h0000_1000, 0, 1, "R1 all windows disabled");
        req(32'h0000_0000, 1, 0, "R9 later deny keeps record");
        cfg(0, 3, '0);
        step("R10 clear");

        // attr bits: 0 en, 1 s_rd, 2 s_wr, 3 ns_rd, 4 ns_wr, 5 secure space
        region(0, 32'h0000_1000, 32'h0000_1FFF, 6'h1F);
        region(3, 32'h0000_1800, 32'h0000_18FF, 6'h03);
        region(5, 32'h0000_0000, 32'hFFFF_FFFF, 6'h1E);
        region(7, 32'h0000_4000, 32'h0000_4FFF, 6'h3F);

        req(32'h0000_1000, 0, 0, "R2 base inclusive");
        req(32'h0000_1FFF, 1, 0, "R2 top inclusive");
        req(32'h0000_2000, 0, 1, "R4 past top");
        req(32'h0000_0FFF, 0, 1, "R2 disabled window ignored below base");
        step("R9 record held");
        req(32'h0000_1800, 0, 0, "R3 higher window wins ns read");
        req(32'h0000_18FF, 0, 1, "R5 secure read allowed");
        req(32'h0000_1880, 1, 1, "R5 secure write refused");
        cfg(0, 3, '0);
        req(32'h0000_4000, 0, 0, "R6 secure space refuses ns read");
        req(32'h0000_4FFF, 1, 1, "R5 secure write in secure space");
        req(32'h0000_4800, 1, 0, "R6 secure space refuses ns write");

        // Clear and a new refusal at the same edge
        cfg_we = 1; cfg_idx = '0; cfg_sel = 2'd3; cfg_wdata = '0;
        req(32'h0000_9000, 1, 0, "R10 clear with deny");
        cfg_we = 0;
        step("R10 record kept");

        // Backpressure
        resp_ready = 0;
        req(32'h0000_1100, 0, 0, "R8 stall accept");
        req(32'h0000_2100, 0, 0, "R8 stalled hold");
        req_valid = 1; req_addr = 32'h0000_7000;
        step("R8 stalled hold 2");
        step("R8 stalled hold 3");
        resp_ready = 1;
        step("R8 release accepts");
        req_valid = 0;
        step("R7 drain");
        step("R7 idle");

        // Config write at the same edge as a request
        cfg_we = 1; cfg_idx = 3'd0; cfg_sel = 2'd2; cfg_wdata = '0;
        req(32'h0000_1000, 0, 0, "R11 old settings used");
        cfg_we = 0;
        req(32'h0000_1000, 0, 0, "R11 new settings used");
        cfg(0, 3, '0);
        req(32'h0000_1000, 0, 0, "R4 no match after disable");
        step("R9 capture");

        // Back-to-back requests
        req_valid = 1;
        for (int k = 0; k < 6; k++) begin
            req_addr = 32'h0000_1800 + AW'(k * 32'h400);
            req_write = k[0]; req_secure = k[1];
            step("R7 back to back");
        end
        req_valid = 0;
        step("R7 drain");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule